// File: doc/BRIEF.md
# CAN Controller Status and Interrupt Unit

This block is the status, interrupt-flag, interrupt-enable and command part of a byte-addressed CAN controller register file. A host reads and writes its registers over a simple single-cycle bus (address, write data, write enable, read enable). The receive path reports three kinds of events to it as one-cycle pulses: a message was stored in the receive buffer, a message was lost to overrun, and the buffer became empty. The unit turns these events, host commands and enable settings into one level-sensitive interrupt line.

Host commands are written to the command register as bit flags. A transmit request takes effect at once: the unit updates its status, raises the transmit flag and strobes `tx_done` towards the bus side. A release-buffer request is forwarded to the receive path as a strobe, and a clear-overrun request drops the overrun status and flag. Writing the mode register with its reset bit set while the controller is operating performs a software reset. That reset reloads parts of mode and status and strobes `rx_reset` so the receive path can zero its pointers and counts.

Top module: `can_siu_top`

## Requirements
- R1: The register map is mode at 0, command at 1, status at 2, interrupt flags at 3, interrupt enable at 4 and the first transmit-buffer byte at 16. After hardware reset, mode reads 0x01 (bit 0 means reset mode), status reads 0x3C, flags read 0x00 and `irq` is low.
- R2: A mode write with bit 0 set while mode bit 0 is clear is a software reset. Mode becomes (wdata & 0x1F & ~0x31) | 0x01 and status becomes (status & ~0x37) | 0x34. `rx_reset` pulses in the following cycle, and the remembered queued-message state is cleared.
- R3: A command write with bit 0 set sets status bits 2 and 3, clears status bit 5 and sets flag bit 1. `tx_done` pulses for one cycle in the following cycle.
- R4: A command write with bit 3 set clears status bit 1 (overrun) and flag bit 3.
- R5: A command write with bit 2 set pulses `rel_buf` for one cycle in the following cycle and changes no register.
- R6: `rx_stored` sets status bit 0 and flag bit 0, clears status bit 4 and marks a message as queued. `rx_empty` clears status bit 0 and flag bit 0 and marks the queue empty.
- R7: `rx_overrun` sets status bit 1 and flag bit 3 and clears status bit 4.
- R8: Reading the flag register returns its value and clears every flag. Flag bit 0 is set again in the same update if a message is still queued.
- R9: `irq` is registered and is high exactly when some flag among bits 0, 1 and 3 has its enable bit set. It changes on the same edge as the flags. Enable bits 2 and 4 to 7 have no effect on `irq`.
- R10: A write to the first transmit-buffer address sets status bit 5 only in operating mode (mode bit 0 clear). In reset mode it has no effect on status.
- R11: Read data is registered and valid in the cycle after `rd_en`. The command register and unused addresses read 0x00, and the enable register reads back what was written.
- R12: When a set event and a clear event for the same status or flag bit arrive in the same cycle, the bit ends up set.
- R13: A mode write that does not enter reset stores only bits 4:0 of the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| rx_stored | input | 1 | Receive path stored a message |
| rx_overrun | input | 1 | Receive path lost a message to overrun |
| rx_empty | input | 1 | Receive buffer became empty |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt line |
| tx_done | output | 1 | Transmission-complete strobe to the bus side |
| rel_buf | output | 1 | Release-buffer strobe to the receive path |
| rx_reset | output | 1 | Software-reset strobe to the receive path |

## Verification
A flag or status bit left in the wrong state appears on `irq` on the edge right after the event that set it, provided its enable is on. With the enable off, it shows on the next read of status or flags, one cycle after `rd_en`. A lost queued-message state shows only when the flag register is read twice: the second read returns 0x00 instead of 0x01. For this reason the tests read the flags back to back after receive events, software reset and simultaneous set/clear pulses. Priority errors between set and clear are invisible unless both events land in the same cycle, so the stimulus does exactly that.

// File: rtl/can_siu_pkg.sv
// Shared constants and types for the CAN status/interrupt unit.
// Assumes an 8-bit register file; addresses are small integers cast to
// the address width chosen at the top.
package can_siu_pkg;
    localparam int DW = 8;

    localparam int A_MODE = 0;
    localparam int A_CMD  = 1;
    localparam int A_STAT = 2;
    localparam int A_IFLG = 3;
    localparam int A_IEN  = 4;
    localparam int A_TXB0 = 16;

    localparam logic [DW-1:0] MODE_WMASK   = 8'h1F;
    localparam logic [DW-1:0] MODE_HW      = 8'h01;
    localparam logic [DW-1:0] STAT_HW      = 8'h3C;
    localparam logic [DW-1:0] SWR_MODE_CLR = 8'h31;
    localparam logic [DW-1:0] SWR_STAT_CLR = 8'h37;
    localparam logic [DW-1:0] SWR_STAT_SET = 8'h34;
    localparam logic [DW-1:0] IRQ_SRC_MASK = 8'h0B;

    // Decoded host operations for one cycle.
    typedef struct packed {
        logic mode_wr;
        logic tx_req;
        logic rel_req;
        logic clrov_req;
        logic ien_wr;
        logic txb_wr;
        logic flg_rd;
    } host_ops_t;
endpackage

// File: rtl/can_siu_decode.sv
// Host bus decoder: turns address, strobes and command bits into one-cycle
// operation strobes. Assumes wr_en and rd_en are single-cycle qualified.
module can_siu_decode
    import can_siu_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        cmd_bits,   // {clear-overrun, release, transmit}
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              mode_rst,
    output host_ops_t         ops
);
    logic is_cmd;

    // Command register hit on a write.
    assign is_cmd = wr_en && (addr == ADDR_W'(A_CMD));

    // Build the operation strobes.
    always_comb begin
        ops           = '0;
        ops.mode_wr   = wr_en && (addr == ADDR_W'(A_MODE));
        ops.tx_req    = is_cmd && cmd_bits[0];
        ops.rel_req   = is_cmd && cmd_bits[1];
        ops.clrov_req = is_cmd && cmd_bits[2];
        ops.ien_wr    = wr_en && (addr == ADDR_W'(A_IEN));
        ops.txb_wr    = wr_en && (addr == ADDR_W'(A_TXB0)) && !mode_rst;
        ops.flg_rd    = rd_en && (addr == ADDR_W'(A_IFLG));
    end
endmodule

// File: rtl/can_siu_state.sv
// Mode and status registers with software reset. Set events win over clear
// events on the same bit; a software reset overrides both.
module can_siu_state
    import can_siu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  host_ops_t     ops,
    input  logic [DW-1:0] wdata,
    input  logic          rx_stored,
    input  logic          rx_overrun,
    input  logic          rx_empty,
    output logic [DW-1:0] mode_q,
    output logic [DW-1:0] stat_q,
    output logic          sw_rst
);
    logic [DW-1:0] mode_nxt, stat_nxt, st_set, st_clr;

    // Software reset: entering reset mode from operating mode.
    assign sw_rst = ops.mode_wr && wdata[0] && !mode_q[0];

    // Next mode value.
    always_comb begin
        mode_nxt = mode_q;
        if (ops.mode_wr) mode_nxt = wdata & MODE_WMASK;
        if (sw_rst)      mode_nxt = (wdata & MODE_WMASK & ~SWR_MODE_CLR) | MODE_HW;
    end

    // Next status value from events, set winning over clear.
    always_comb begin
        st_set = '0;
        st_clr = '0;
        if (rx_empty)                st_clr[0] = 1'b1;
        if (ops.clrov_req)           st_clr[1] = 1'b1;
        if (rx_stored || rx_overrun) st_clr[4] = 1'b1;
        if (ops.tx_req)              st_clr[5] = 1'b1;
        if (rx_stored)               st_set[0] = 1'b1;
        if (rx_overrun)              st_set[1] = 1'b1;
        if (ops.tx_req)              st_set[3:2] = 2'b11;
        if (ops.txb_wr)              st_set[5] = 1'b1;
        stat_nxt = (stat_q & ~st_clr) | st_set;
        if (sw_rst) stat_nxt = (stat_q & ~SWR_STAT_CLR) | SWR_STAT_SET;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_HW;
            stat_q <= STAT_HW;
        end else begin
            mode_q <= mode_nxt;
            stat_q <= stat_nxt;
        end
    end

    a_r3_tx_status: assert property (@(posedge clk) disable iff (!rst_n)
        ops.tx_req |=> (stat_q[3:2] == 2'b11) && !stat_q[5]);
    a_r4_clear_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (ops.clrov_req && !rx_overrun) |=> !stat_q[1]);
    a_r6_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stored && !sw_rst) |=> stat_q[0] && !stat_q[4]);
    a_r10_txb_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ops.txb_wr && !sw_rst) |=> stat_q[5]);
    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stored && rx_empty && !sw_rst) |=> stat_q[0]);
endmodule

// File: rtl/can_siu_intr.sv
// Interrupt flags, enable register, queued-message memory and the
// registered interrupt line. Flag reads clear all flags; the receive flag
// re-arms while a message is queued. Set wins over clear.
module can_siu_intr
    import can_siu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  host_ops_t     ops,
    input  logic [DW-1:0] wdata,
    input  logic          rx_stored,
    input  logic          rx_overrun,
    input  logic          rx_empty,
    input  logic          sw_rst,
    output logic [DW-1:0] flg_q,
    output logic [DW-1:0] ien_q,
    output logic          irq_o
);
    logic [DW-1:0] flg_nxt, ien_nxt, f_set, f_clr;
    logic          pend_q, pend_nxt;

    // Queued-message memory: a store wins over empty or software reset.
    always_comb begin
        pend_nxt = pend_q;
        if (rx_empty || sw_rst) pend_nxt = 1'b0;
        if (rx_stored)          pend_nxt = 1'b1;
    end

    // Next flag and enable values.
    always_comb begin
        f_set = '0;
        f_clr = '0;
        if (ops.flg_rd)    f_clr = '1;
        if (rx_empty)      f_clr[0] = 1'b1;
        if (ops.clrov_req) f_clr[3] = 1'b1;
        if (rx_stored || (ops.flg_rd && pend_q && !rx_empty)) f_set[0] = 1'b1;
        if (ops.tx_req)    f_set[1] = 1'b1;
        if (rx_overrun)    f_set[3] = 1'b1;
        flg_nxt = (flg_q & ~f_clr) | f_set;
        ien_nxt = ops.ien_wr ? wdata : ien_q;
    end

    // Registers, including the interrupt line built from next values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q  <= '0;
            ien_q  <= '0;
            pend_q <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            flg_q  <= flg_nxt;
            ien_q  <= ien_nxt;
            pend_q <= pend_nxt;
            irq_o  <= |(flg_nxt & ien_nxt & IRQ_SRC_MASK);
        end
    end

    a_r8_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (ops.flg_rd && pend_q && !rx_empty) |=> flg_q[0]);
    a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(flg_q & ien_q & IRQ_SRC_MASK));
endmodule

// File: rtl/can_siu_top.sv
// Top of the CAN status/interrupt unit: host decode, state, interrupt
// logic, registered read mux and one-cycle strobes to the bus and receive
// paths. Assumes receive events are one-cycle pulses.
module can_siu_top
    import can_siu_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              rx_stored,
    input  logic              rx_overrun,
    input  logic              rx_empty,
    output logic [DW-1:0]     rdata,
    output logic              irq,
    output logic              tx_done,
    output logic              rel_buf,
    output logic              rx_reset
);
    host_ops_t     ops;
    logic [DW-1:0] mode_q, stat_q, flg_q, ien_q, rd_mux;
    logic          sw_rst;

    can_siu_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr     (addr),
        .cmd_bits ({wdata[3], wdata[2], wdata[0]}),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .mode_rst (mode_q[0]),
        .ops      (ops)
    );

    can_siu_state st_i (
        .clk, .rst_n, .ops, .wdata,
        .rx_stored, .rx_overrun, .rx_empty,
        .mode_q, .stat_q, .sw_rst
    );

    can_siu_intr in_i (
        .clk, .rst_n, .ops, .wdata,
        .rx_stored, .rx_overrun, .rx_empty, .sw_rst,
        .flg_q, .ien_q, .irq_o (irq)
    );

    // Read mux over current register values.
    always_comb begin
        rd_mux = '0;
        if (addr == ADDR_W'(A_MODE)) rd_mux = mode_q;
        if (addr == ADDR_W'(A_STAT)) rd_mux = stat_q;
        if (addr == ADDR_W'(A_IFLG)) rd_mux = flg_q;
        if (addr == ADDR_W'(A_IEN))  rd_mux = ien_q;
    end

    // Registered read data and outgoing strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            tx_done  <= 1'b0;
            rel_buf  <= 1'b0;
            rx_reset <= 1'b0;
        end else begin
            if (rd_en) rdata <= rd_mux;
            tx_done  <= ops.tx_req;
            rel_buf  <= ops.rel_req;
            rx_reset <= sw_rst;
        end
    end
endmodule

// File: tb/can_siu_tb_top.sv
`timescale 1ns/1ps
module can_siu_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic       rx_stored = 1'b0, rx_overrun = 1'b0, rx_empty = 1'b0;
    logic [7:0] rdata;
    logic       irq, tx_done, rel_buf, rx_reset;
    logic       s_tx, s_rel, s_rrst;
    logic [7:0] v;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    can_siu_top #(.ADDR_W(5)) dut_i (
        .clk, .rst_n, .addr, .wdata, .wr_en, .rd_en,
        .rx_stored, .rx_overrun, .rx_empty,
        .rdata, .irq, .tx_done, .rel_buf, .rx_reset
    );

    // Vector: {is_read, addr, data, expected, requirement number}
    localparam int NV = 18;
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 8'd4,  8'h0B, 8'h00, 8'd9},   // R9 enable receive, transmit, overrun
        {1'b0, 8'd0,  8'h00, 8'h00, 8'd13},  // R13 leave reset mode
        {1'b1, 8'd0,  8'h00, 8'h00, 8'd13},  // R13 mode reads 0x00
        {1'b0, 8'd1,  8'h01, 8'h00, 8'd3},   // R3 transmit request
        {1'b1, 8'd2,  8'h00, 8'h1C, 8'd3},   // R3 status 0x1C
        {1'b1, 8'd3,  8'h00, 8'h02, 8'd8},   // R8 transmit flag read
        {1'b1, 8'd3,  8'h00, 8'h00, 8'd8},   // R8 cleared by read
        {1'b0, 8'd16, 8'h55, 8'h00, 8'd10},  // R10 transmit byte in operating mode
        {1'b1, 8'd2,  8'h00, 8'h3C, 8'd10},  // R10 status bit5 set
        {1'b1, 8'd1,  8'h00, 8'h00, 8'd11},  // R11 command reads zero
        {1'b1, 8'd4,  8'h00, 8'h0B, 8'd11},  // R11 enable readback
        {1'b1, 8'd7,  8'h00, 8'h00, 8'd11},  // R11 unused address
        {1'b0, 8'd0,  8'hFF, 8'h00, 8'd2},   // R2 software reset
        {1'b1, 8'd0,  8'h00, 8'h0F, 8'd2},   // R2 mode 0x0F
        {1'b1, 8'd2,  8'h00, 8'h3C, 8'd2},   // R2 status 0x3C
        {1'b0, 8'd1,  8'h01, 8'h00, 8'd3},   // R3 transmit in reset mode
        {1'b0, 8'd16, 8'h11, 8'h00, 8'd10},  // R10 ignored in reset mode
        {1'b1, 8'd2,  8'h00, 8'h1C, 8'd10}   // R10 status still 0x1C
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a[4:0]; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        s_tx = tx_done; s_rel = rel_buf; s_rrst = rx_reset;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a[4:0]; rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic rx(input logic st, input logic ov, input logic em);
        @(negedge clk);
        rx_stored = st; rx_overrun = ov; rx_empty = em;
        @(posedge clk);
        @(negedge clk);
        rx_stored = 1'b0; rx_overrun = 1'b0; rx_empty = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        check("R1 irq", {7'd0, irq}, 8'h00);
        rd(8'd0, v); check("R1 mode", v, 8'h01);
        rd(8'd2, v); check("R1 status", v, 8'h3C);
        rd(8'd3, v); check("R1 flags", v, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][32]) begin
                rd(VEC[i][31:24], v);
                n_chk++;
                if (v !== VEC[i][15:8]) begin
                    n_bad++;
                    $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[i][7:0], i, v, VEC[i][15:8]);
                end
            end else begin
                wr(VEC[i][31:24], VEC[i][23:16]);
            end
        end

        // Fresh hardware reset, then receive path tests.
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        rd(8'd2, v); check("R1 status after reset", v, 8'h3C);
        wr(8'd4, 8'h01);
        wr(8'd0, 8'h00);
        rx(1'b1, 1'b0, 1'b0);
        check("R9 irq on receive", {7'd0, irq}, 8'h01);
        rd(8'd2, v); check("R6 status stored", v, 8'h2D);
        rd(8'd3, v); check("R8 first read", v, 8'h01);
        rd(8'd3, v); check("R8 rearmed flag", v, 8'h01);
        check("R8 irq held", {7'd0, irq}, 8'h01);
        rx(1'b0, 1'b0, 1'b1);
        check("R6 irq after empty", {7'd0, irq}, 8'h00);
        rd(8'd2, v); check("R6 status empty", v, 8'h2C);
        rd(8'd3, v); check("R6 flags empty", v, 8'h00);

        // R7 overrun, masked then enabled; R4 clear
        rx(1'b0, 1'b1, 1'b0);
        check("R9 overrun masked", {7'd0, irq}, 8'h00);
        rd(8'd2, v); check("R7 status overrun", v, 8'h2E);
        wr(8'd4, 8'h08);
        check("R9 overrun enabled", {7'd0, irq}, 8'h01);
        wr(8'd1, 8'h08);
        check("R4 irq cleared", {7'd0, irq}, 8'h00);
        rd(8'd2, v); check("R4 status", v, 8'h2C);

        // R9 non-source enable bits; R3 strobe
        wr(8'd4, 8'hF4);
        wr(8'd1, 8'h01);
        check("R3 tx_done", {7'd0, s_tx}, 8'h01);
        check("R9 ignored enables", {7'd0, irq}, 8'h00);
        rd(8'd2, v); check("R3 status", v, 8'h0C);
        rd(8'd3, v); check("R3 flag", v, 8'h02);

        // R5 release strobe
        wr(8'd1, 8'h04);
        check("R5 rel_buf", {7'd0, s_rel}, 8'h01);
        check("R5 no tx_done", {7'd0, s_tx}, 8'h00);
        rd(8'd2, v); check("R5 status unchanged", v, 8'h0C);

        // R12 simultaneous set and clear
        rx(1'b1, 1'b0, 1'b1);
        rd(8'd2, v); check("R12 status bit0", v, 8'h0D);
        rd(8'd3, v); check("R12 flag bit0", v, 8'h01);
        rd(8'd3, v); check("R12 still queued", v, 8'h01);
        rx(1'b0, 1'b0, 1'b1);
        rd(8'd3, v); check("R6 flag drained", v, 8'h00);

        // R2 software reset clears queued-message memory
        rx(1'b1, 1'b0, 1'b0);
        wr(8'd0, 8'h01);
        check("R2 rx_reset", {7'd0, s_rrst}, 8'h01);
        rd(8'd0, v); check("R2 mode", v, 8'h01);
        rd(8'd2, v); check("R2 status", v, 8'h3C);
        rd(8'd3, v); check("R2 flag kept", v, 8'h01);
        rd(8'd3, v); check("R2 queue cleared", v, 8'h00);

        // R13 leaving reset keeps bits 4:0
        wr(8'd0, 8'hE6);
        check("R13 no rx_reset", {7'd0, s_rrst}, 8'h00);
        rd(8'd0, v); check("R13 mode mask", v, 8'h06);

        done = 1'b1;
        finish_run();
    end
endmodule